// File: doc/BRIEF.md
# Decode-Stage Dependence Check and Forwarding Selector

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode with register read, execute or address generation, memory access, writeback). Each cycle it takes the register indices the decoding instruction reads. For the two older instructions in the execute and memory stages it also takes the destination index and a register-write flag, and for the execute stage a load flag. All of its logic is combinational.

For every source operand it returns a forwarding select. The datapath registers that select into ID/EX along with the instruction, and uses it one cycle later to pick the operand from the register file, the EX/MEM result or the MEM/WB result. The block checks only true (read-after-write) dependences. A matching producer hands its value forward as soon as the pipeline holds it, so the consumer does not wait for writeback.

The one case forwarding cannot cover is a load in the execute stage whose destination a decode source reads. Its data is not available until the end of the memory stage. The block then raises a one-cycle stall that holds the PC and IF/ID and turns the next ID/EX entry into a bubble.

Top module: `hz_bypass_unit`

## Requirements
- R1: A source equal to the execute-stage destination, with that stage's write flag high and load flag low, gives select code 1 (EX/MEM result) and no stall.
- R2: A source that matches the memory-stage destination (write flag high) and does not match the execute stage gives select code 2 (MEM/WB result).
- R3: When a source matches both the execute-stage and the memory-stage destinations, the execute-stage (younger) producer wins and the select is code 1.
- R4: A source that matches an execute-stage destination whose load flag and write flag are both high drives pc_hold_o, ifid_hold_o and idex_bubble_o high in that same cycle.
- R5: A load in the memory stage that matches a source causes no stall and gives select code 2.
- R6: Register index 0 never matches. A destination of 0 with write and load flags high produces select code 0 and no stall.
- R7: A stage whose write flag is low is never matched, whatever its destination index.
- R8: Only a matching load in the execute stage stalls. A matching non-load in the execute stage, a matching load in the memory stage, or no match at all leaves all three stall outputs low.
- R9: Each source is compared on its own. Source element 0 and element 1 get independent selects, and a stall from either source stalls the whole instruction.
- R10: With no match, the select is code 0 (register file). This covers a producer three or more stages ahead, which the write-first register file already supplies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_idx_i | input | NSRC x AW | Decode-stage source register indices, element 0 is the first operand |
| ex_rd_i | input | AW | Destination index of the instruction in execute |
| ex_wr_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | AW | Destination index of the instruction in memory |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| fwd_sel_o | output | NSRC x 2 | Per-source select: 0 register file, 1 EX/MEM, 2 MEM/WB |
| pc_hold_o | output | 1 | Hold the PC this cycle |
| ifid_hold_o | output | 1 | Hold the IF/ID register this cycle |
| idex_bubble_o | output | 1 | Load a bubble into ID/EX this cycle |

## Verification
There is no stored state, so any fault appears at the ports in the same cycle as the input pattern that triggers it. A wrong select shows as a code that disagrees with the producer distance. A wrong priority shows only when both stages carry the same destination. A stall fault shows as a missing hold after a matching execute-stage load, or as a spurious hold on a non-load or memory-stage match. The bench therefore sweeps every register index against producers one, two and three stages ahead, with and without the load flag, and adds random patterns drawn from a small index range so that matches in both stages at once are frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Operand source selected for an instruction once it reaches execute.
  typedef enum logic [1:0] {
    SEL_RF    = 2'd0,
    SEL_EXMEM = 2'd1,
    SEL_MEMWB = 2'd2
  } fwd_sel_e;

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_wr_i,
  input  logic          ex_load_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_wr_i,
  output fwd_sel_e      sel_o,
  output logic          stall_o
);

  logic ex_hit;
  logic mem_hit;

  // A producer only counts when it really writes and its target is not r0.
  assign ex_hit  = ex_wr_i  && (ex_rd_i  != '0) && (ex_rd_i  == src_i);
  assign mem_hit = mem_wr_i && (mem_rd_i != '0) && (mem_rd_i == src_i);

  // Selects are consumed one cycle later, when the current execute-stage
  // producer has moved to EX/MEM and the memory-stage producer to MEM/WB.
  always_comb begin
    if (ex_hit) begin
      sel_o = SEL_EXMEM;
    end else if (mem_hit) begin
      sel_o = SEL_MEMWB;
    end else begin
      sel_o = SEL_RF;
    end
  end

  // Load data exists only after the memory stage: one bubble is needed.
  assign stall_o = ex_hit && ex_load_i;

  // R7
  always_comb begin : wr_gate_blk
    ex_wr_gate_chk: assert (ex_wr_i || (sel_o != SEL_EXMEM))
      else $error("EX/MEM select without a writing producer");
  end

endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl #(
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0] stall_req_i,
  output logic            pc_hold_o,
  output logic            ifid_hold_o,
  output logic            idex_bubble_o
);

  logic stall_any;

  assign stall_any     = |stall_req_i;
  assign pc_hold_o     = stall_any;
  assign ifid_hold_o   = stall_any;
  assign idex_bubble_o = stall_any;

endmodule

// File: rtl/hz_bypass_unit.sv
module hz_bypass_unit
  import hz_pkg::*;
#(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] src_idx_i,
  input  logic [AW-1:0]           ex_rd_i,
  input  logic                    ex_wr_i,
  input  logic                    ex_load_i,
  input  logic [AW-1:0]           mem_rd_i,
  input  logic                    mem_wr_i,
  output logic [NSRC-1:0][1:0]    fwd_sel_o,
  output logic                    pc_hold_o,
  output logic                    ifid_hold_o,
  output logic                    idex_bubble_o
);

  fwd_sel_e        sel_w [NSRC];
  logic [NSRC-1:0] stall_req;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_cmp #(.AW(AW)) u_cmp (
      .src_i     (src_idx_i[g]),
      .ex_rd_i   (ex_rd_i),
      .ex_wr_i   (ex_wr_i),
      .ex_load_i (ex_load_i),
      .mem_rd_i  (mem_rd_i),
      .mem_wr_i  (mem_wr_i),
      .sel_o     (sel_w[g]),
      .stall_o   (stall_req[g])
    );
    assign fwd_sel_o[g] = sel_w[g];
  end

  hz_stall_ctl #(.NSRC(NSRC)) u_stall (
    .stall_req_i   (stall_req),
    .pc_hold_o     (pc_hold_o),
    .ifid_hold_o   (ifid_hold_o),
    .idex_bubble_o (idex_bubble_o)
  );

  always_comb begin : chk_blk
    for (int i = 0; i < NSRC; i++) begin
      // R6
      zero_src_chk: assert ((src_idx_i[i] != '0) || (fwd_sel_o[i] == 2'd0))
        else $error("register 0 source was forwarded");
      // R4
      load_use_stall_chk: assert (!(ex_load_i && ex_wr_i && (ex_rd_i != '0)
                                    && (src_idx_i[i] == ex_rd_i)) || pc_hold_o)
        else $error("load-use match without stall");
      // R3
      young_first_chk: assert (!(ex_wr_i && mem_wr_i && (ex_rd_i != '0)
                                 && (ex_rd_i == mem_rd_i) && (src_idx_i[i] == ex_rd_i))
                               || (fwd_sel_o[i] == 2'd1))
        else $error("older producer chosen over younger");
    end
    // R8
    stall_cause_chk: assert (!pc_hold_o || (ex_load_i && ex_wr_i))
      else $error("stall without a load in execute");
  end

endmodule

// File: tb/hz_bypass_unit_tb.sv
`timescale 1ns/1ps
module hz_bypass_unit_tb;

  localparam int AW   = 5;
  localparam int NSRC = 2;

  logic clk;
  logic [NSRC-1:0][AW-1:0] src_idx;
  logic [AW-1:0]           ex_rd;
  logic                    ex_wr;
  logic                    ex_load;
  logic [AW-1:0]           mem_rd;
  logic                    mem_wr;
  logic [NSRC-1:0][1:0]    fwd_sel;
  logic                    pc_hold;
  logic                    ifid_hold;
  logic                    idex_bubble;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 0;

  typedef struct {
    logic [NSRC-1:0][1:0] sel;
    logic [NSRC-1:0]      chk_sel;
    logic                 stall;
    string                tag;
  } exp_t;

  exp_t sb_q[$];

  hz_bypass_unit #(.AW(AW), .NSRC(NSRC)) u_dut (
    .src_idx_i     (src_idx),
    .ex_rd_i       (ex_rd),
    .ex_wr_i       (ex_wr),
    .ex_load_i     (ex_load),
    .mem_rd_i      (mem_rd),
    .mem_wr_i      (mem_wr),
    .fwd_sel_o     (fwd_sel),
    .pc_hold_o     (pc_hold),
    .ifid_hold_o   (ifid_hold),
    .idex_bubble_o (idex_bubble)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Driver: drive at the falling edge, push the model's expectation.
  task automatic apply(input logic [AW-1:0] s0, input logic [AW-1:0] s1,
                       input logic [AW-1:0] erd, input logic ew, input logic el,
                       input logic [AW-1:0] mrd, input logic mw, input string tag);
    exp_t e;
    logic [AW-1:0] s;
    logic eh, mh;
    @(negedge clk);
    src_idx[0] = s0; src_idx[1] = s1;
    ex_rd = erd; ex_wr = ew; ex_load = el; mem_rd = mrd; mem_wr = mw;
    e.stall = 1'b0;
    e.tag   = tag;
    for (int i = 0; i < NSRC; i++) begin
      s  = (i == 0) ? s0 : s1;
      eh = (s != 0) && ew && (erd == s);
      mh = (s != 0) && mw && (mrd == s);
      e.chk_sel[i] = 1'b1;
      if (eh && el) begin
        e.stall      = 1'b1;
        e.chk_sel[i] = 1'b0;
        e.sel[i]     = 2'd0;
      end else if (eh) e.sel[i] = 2'd1;
      else if (mh)     e.sel[i] = 2'd2;
      else             e.sel[i] = 2'd0;
    end
    sb_q.push_back(e);
  endtask

  // Monitor: compare at the following rising edge, long after inputs settled.
  always @(posedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_vec++;
      if ({pc_hold, ifid_hold, idex_bubble} !== {3{e.stall}}) begin
        n_miss++;
        $display("FAIL %s stall: got %b%b%b exp %b", e.tag, pc_hold, ifid_hold,
                 idex_bubble, e.stall);
      end
      for (int i = 0; i < NSRC; i++) begin
        if (e.chk_sel[i] && (fwd_sel[i] !== e.sel[i])) begin
          n_miss++;
          $display("FAIL %s sel[%0d]: got %0d exp %0d", e.tag, i, fwd_sel[i], e.sel[i]);
        end
      end
    end
  end

  initial begin
    src_idx = '0; ex_rd = '0; ex_wr = 0; ex_load = 0; mem_rd = '0; mem_wr = 0;
    apply(0, 0, 0, 0, 0, 0, 0, "R10 idle state");
    apply(5, 9, 5, 1, 0, 0, 0, "R1 ex forward");
    apply(3, 7, 7, 1, 0, 0, 0, "R9 second source ex forward");
    apply(5, 9, 2, 1, 0, 5, 1, "R2 mem forward");
    apply(5, 5, 5, 1, 0, 5, 1, "R3 younger wins");
    apply(5, 9, 5, 1, 1, 0, 0, "R4 load-use src0");
    apply(4, 6, 6, 1, 1, 4, 1, "R4 load-use src1 with R9 mem on src0");
    apply(5, 9, 1, 1, 1, 5, 1, "R5 load in mem");
    apply(0, 0, 0, 1, 1, 0, 1, "R6 register zero");
    apply(5, 9, 5, 0, 1, 0, 0, "R7 ex write flag low");
    apply(5, 9, 5, 0, 0, 5, 1, "R7 ex off falls to mem");
    apply(5, 9, 3, 1, 0, 9, 0, "R7 mem write flag low");
    apply(8, 8, 8, 1, 0, 8, 1, "R8 non-load ex no stall");
    // Distance sweep: producer 1, 2 and 3+ stages ahead for every index.
    for (int r = 0; r < 32; r++) begin
      for (int ld = 0; ld < 2; ld++) begin
        apply(r[AW-1:0], 0, r[AW-1:0], 1, ld[0], 0, 0, "R4 R1 sweep distance 1");
        apply(r[AW-1:0], 0, 0, 0, 0, r[AW-1:0], 1, "R2 R5 sweep distance 2");
        apply(0, r[AW-1:0], 0, 0, 0, 0, 0, "R10 sweep distance 3");
      end
    end
    // Random patterns over a small index range so matches collide.
    for (int k = 0; k < 300; k++) begin
      logic [31:0] v;
      v = $urandom;
      apply({3'b0, v[1:0]}, {3'b0, v[3:2]}, {3'b0, v[5:4]}, v[6], v[7],
            {3'b0, v[9:8]}, v[10], "R3 R9 random mix");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

endmodule